// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a single-cycle 32-bit processor. On each rising clock edge it loads a new address, chosen by a 3-bit select that the control logic has already resolved. The choices are the next sequential word, a PC-relative branch target, a region-relative jump target, an address taken from a register, and three fixed handler addresses: one for reset, one for interrupts and one for illegal opcodes. A code outside the defined set falls back to sequential fetch.

The branch target comes from an adder inside this block, separate from the datapath ALU. The 16-bit immediate is sign-extended and shifted left by two bits through wiring alone. The jump target keeps the upper four bits of the current PC and appends the 26-bit jump field and two zero bits. The current PC plus four is also brought out combinationally, so the datapath can store it as a link address or an exception return address.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0x80000000 on that edge, whatever the value of `pc_sel`.
- R2: With `pc_sel` = 0, the PC becomes PC+4 on the edge, wrapping modulo 2^32 (0xFFFFFFFC goes to 0x00000000).
- R3: With `pc_sel` = 1, the PC becomes PC + 4 + 4 × sign-extended `imm16`. Bit 15 of `imm16` is the sign bit, so 0x8000 moves the PC back by 131068 bytes.
- R4: With `pc_sel` = 2, the PC becomes {PC[31:28], `jfield`[25:0], 2'b00}.
- R5: With `pc_sel` = 3, the PC becomes `reg_tgt` exactly, including its two low bits.
- R6: With `pc_sel` = 4 (illegal opcode), the PC becomes 0x80000040.
- R7: With `pc_sel` = 5 (interrupt), the PC becomes 0x80000080.
- R8: With `pc_sel` = 6, the PC becomes 0x80000000 even when `rst` is low.
- R9: With `pc_sel` = 7 (undefined), the PC becomes PC+4, the same as code 0.
- R10: `pc_plus4` always equals the current `pc` plus 4, modulo 2^32, in the same cycle.
- R11: `imm16` has no effect on the next PC unless `pc_sel` = 1, and `jfield` has no effect unless `pc_sel` = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the boot address |
| pc_sel | input | 3 | Next-PC source: 0 sequential, 1 branch, 2 jump, 3 register, 4 illegal-opcode vector, 5 interrupt vector, 6 reset vector, 7 sequential |
| imm16 | input | 16 | Branch offset in words, signed |
| jfield | input | 26 | Word-address field of a jump |
| reg_tgt | input | 32 | Register value used for indirect jumps |
| pc | output | 32 | Current program counter (registered) |
| pc_plus4 | output | 32 | Current program counter plus four |

## Verification
The program counter is the only state in this block. A wrong source choice, a bad sign extension or a wrong vector therefore shows on `pc` on the first edge after the faulty selection. `pc_plus4` shows the same error in that cycle and passes it on to every sequential step that follows. The bench places the PC at chosen addresses through the register path and then sweeps all eight select codes. The sweep uses pseudo-random immediates, jump fields and PC values, plus the wrap-around, negative-offset and reset-priority corners, so a fault is caught one edge after it happens.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    SRC_SEQ   = 3'd0,
    SRC_BR    = 3'd1,
    SRC_JMP   = 3'd2,
    SRC_REG   = 3'd3,
    SRC_ILL   = 3'd4,
    SRC_IRQ   = 3'd5,
    SRC_BOOT  = 3'd6,
    SRC_SPARE = 3'd7
  } pc_src_e;
endpackage

// File: rtl/pcu_target_gen.sv
// Branch and jump target arithmetic, independent of the datapath ALU.
module pcu_target_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JF_W  = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  pc_plus4,
  input  logic [IMM_W-1:0] imm,
  input  logic [JF_W-1:0]  jf,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jmp_tgt
);
  localparam int EXT_W    = XLEN - IMM_W;
  localparam int REGION_W = XLEN - JF_W - 2;

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    // word offset: shift by two is pure wiring
    br_tgt  = pc_plus4 + (imm_ext << 2);
    jmp_tgt = {pc[XLEN-1 -: REGION_W], jf, 2'b00};
  end
endmodule

// File: rtl/pcu_next_mux.sv
// Seven-way next-address selection; the spare code falls back to sequential.
module pcu_next_mux #(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] BOOT_VEC = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILL_VEC  = 32'h8000_0040,
  parameter logic [XLEN-1:0] IRQ_VEC  = 32'h8000_0080
) (
  input  pcu_pkg::pc_src_e src,
  input  logic [XLEN-1:0]  seq,
  input  logic [XLEN-1:0]  br,
  input  logic [XLEN-1:0]  jmp,
  input  logic [XLEN-1:0]  rtg,
  output logic [XLEN-1:0]  nxt
);
  import pcu_pkg::*;

  always_comb begin
    case (src)
      SRC_BR:   nxt = br;
      SRC_JMP:  nxt = jmp;
      SRC_REG:  nxt = rtg;
      SRC_ILL:  nxt = ILL_VEC;
      SRC_IRQ:  nxt = IRQ_VEC;
      SRC_BOOT: nxt = BOOT_VEC;
      default:  nxt = seq;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int              XLEN    = 32,
  parameter int              IMM_W   = 16,
  parameter int              JF_W    = 26,
  parameter logic [XLEN-1:0] BOOT_VEC = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILL_VEC  = 32'h8000_0040,
  parameter logic [XLEN-1:0] IRQ_VEC  = 32'h8000_0080
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       pc_sel,
  input  logic [IMM_W-1:0] imm16,
  input  logic [JF_W-1:0]  jfield,
  input  logic [XLEN-1:0]  reg_tgt,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  pc_plus4
);
  import pcu_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] br_tgt, jmp_tgt, nxt_pc;
  pc_src_e         src;

  assign src      = pc_src_e'(pc_sel);
  assign pc_plus4 = pc + STEP;

  pcu_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JF_W(JF_W)) u_tgt (
    .pc(pc), .pc_plus4(pc_plus4), .imm(imm16), .jf(jfield),
    .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
  );

  pcu_next_mux #(.XLEN(XLEN), .BOOT_VEC(BOOT_VEC), .ILL_VEC(ILL_VEC),
                 .IRQ_VEC(IRQ_VEC)) u_mux (
    .src(src), .seq(pc_plus4), .br(br_tgt), .jmp(jmp_tgt), .rtg(reg_tgt),
    .nxt(nxt_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= BOOT_VEC;
    else     pc <= nxt_pc;
  end

  // R1: first cycle out of reset shows the boot address
  assert_boot_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == BOOT_VEC);
  // R2 and R9: sequential codes advance by the previously presented pc_plus4
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(pc_sel) == 3'd0 || $past(pc_sel) == 3'd7))
      |-> pc == $past(pc_plus4));
  // R4: jump stays in the 256 MB region and is word aligned
  assert_jump_region_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_sel) == 3'd2)
      |-> (pc[XLEN-1 -: 4] == $past(pc[XLEN-1 -: 4]) && pc[1:0] == 2'b00));
  // R5: register target is taken verbatim
  assert_reg_target_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_sel) == 3'd3) |-> pc == $past(reg_tgt));
  // R6
  assert_illegal_vec_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_sel) == 3'd4) |-> pc == ILL_VEC);
  // R7
  assert_irq_vec_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_sel) == 3'd5) |-> pc == IRQ_VEC);
  // R8
  assert_boot_code_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pc_sel) == 3'd6) |-> pc == BOOT_VEC);
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  pc_sel = 3'd0;
  logic [15:0] imm16 = 16'd0;
  logic [25:0] jfield = 26'd0;
  logic [31:0] reg_tgt = 32'd0;
  logic [31:0] pc, pc_plus4;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;  // 50 MHz

  pc_sequencer dut (
    .clk(clk), .rst(rst), .pc_sel(pc_sel), .imm16(imm16), .jfield(jfield),
    .reg_tgt(reg_tgt), .pc(pc), .pc_plus4(pc_plus4)
  );

  function automatic logic [31:0] nextrand(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic logic [31:0] expect_pc(input logic [2:0] s, input logic [31:0] p,
      input logic [15:0] im, input logic [25:0] jf, input logic [31:0] r);
    logic signed [31:0] off;
    off = 32'($signed(im)) * 4;
    case (s)
      3'd1: return p + 32'd4 + off;
      3'd2: return {p[31:28], jf, 2'b00};
      3'd3: return r;
      3'd4: return 32'h8000_0040;
      3'd5: return 32'h8000_0080;
      3'd6: return 32'h8000_0000;
      default: return p + 32'd4;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample at the next negedge
  task automatic step(input logic [2:0] s, input logic [15:0] im,
      input logic [25:0] jf, input logic [31:0] r);
    pc_sel = s; imm16 = im; jfield = jf; reg_tgt = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic place(input logic [31:0] a);
    step(3'd3, 16'h0, 26'h0, a);
  endtask

  function automatic string tag(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset value", pc, 32'h8000_0000);
    chk("R10 plus4 at reset", pc_plus4, 32'h8000_0004);
    rst = 1'b0;

    // sweep all select codes over pseudo-random operands
    for (int n = 0; n < 48; n++) begin
      for (int s = 0; s < 8; s++) begin
        logic [31:0] p0, r;
        logic [15:0] im;
        logic [25:0] jf;
        seed = nextrand(seed); p0 = seed;
        seed = nextrand(seed); im = seed[31:16];
        seed = nextrand(seed); jf = seed[31:6];
        seed = nextrand(seed); r = seed;
        place(p0);
        chk("R5 placement", pc, p0);
        chk("R10 plus4", pc_plus4, p0 + 32'd4);
        step(3'(s), im, jf, r);
        chk(tag(3'(s)), pc, expect_pc(3'(s), p0, im, jf, r));
        chk("R10 plus4 follows", pc_plus4, expect_pc(3'(s), p0, im, jf, r) + 32'd4);
      end
    end

    // R2 wrap and R10 wrap
    place(32'hFFFF_FFFC);
    chk("R10 plus4 wrap", pc_plus4, 32'h0);
    step(3'd0, 16'h1234, 26'h3ff_ffff, 32'h0);
    chk("R2 wrap", pc, 32'h0);
    // R3 most negative and most positive offsets
    place(32'h4000_0000);
    step(3'd1, 16'h8000, 26'h0, 32'h0);
    chk("R3 negative max", pc, 32'h4000_0004 - 32'd131072);
    place(32'h4000_0000);
    step(3'd1, 16'h7FFF, 26'h0, 32'h0);
    chk("R3 positive max", pc, 32'h4000_0004 + 32'h1FFFC);
    step(3'd1, 16'hFFFF, 26'h0, 32'h0);
    chk("R3 offset minus one word", pc, 32'h4002_0000);
    // R4 upper-region boundary
    place(32'hFFFF_FFFC);
    step(3'd2, 16'h0, 26'h000_0001, 32'h0);
    chk("R4 region kept", pc, 32'hF000_0004);
    // R5 unaligned register value kept
    place(32'h1234_5677);
    chk("R5 low bits kept", pc, 32'h1234_5677);
    // R11 imm16 and jfield ignored on other codes
    place(32'h0000_1000);
    step(3'd0, 16'h8001, 26'h2AA_AAAA, 32'hDEAD_BEEF);
    chk("R11 imm/jfield ignored on seq", pc, 32'h0000_1004);
    step(3'd2, 16'hFFFF, 26'h000_0010, 32'h0);
    chk("R11 imm ignored on jump", pc, 32'h0000_0040);
    step(3'd1, 16'h0002, 26'h3FF_FFFF, 32'h0);
    chk("R11 jfield ignored on branch", pc, 32'h0000_004C);
    // R1 reset wins over every select code
    for (int s = 0; s < 8; s++) begin
      place(32'h0000_2000);
      rst = 1'b1;
      step(3'(s), 16'h0100, 26'h100, 32'h0000_3000);
      chk("R1 reset priority", pc, 32'h8000_0000);
      rst = 1'b0;
    end
    step(3'd0, 16'h0, 26'h0, 32'h0);
    chk("R1 leaves reset sequentially", pc, 32'h8000_0004);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule